// File: doc/BRIEF.md
# Memory-Mapped Keyboard and Console Register Window

This block sits beside a processor's 16-bit, word-addressed memory port. It claims the top 512 words of the address space (0xFE00 to 0xFFFF) for device registers and tells the memory array to stay out of any access there. Inside that window it keeps a status and a data register for a keyboard input channel, a status and a data register for a console output channel, and a control register that holds the machine's run latch.

A character from the keyboard side is captured together with a ready flag. Software then either polls the ready flag or enables an interrupt request. Reading the keyboard data register consumes the character. A byte that software writes to the console data register is held toward the display until the display acknowledges it, and the console status then shows done again. Clearing the run bit in the control register drops the run output and halts the machine.

Top module: `io_window`

## Requirements
- R1: `mem_sel` is low for every address from 0xFE00 to 0xFFFF and high for every address below 0xFE00, whatever the strobes are doing.
- R2: Reading 0xFE00 returns the keyboard ready flag in bit 15 and the keyboard interrupt enable in bit 14, with all other bits zero. A write to 0xFE00 changes only the enable, which takes the value of bit 14 of the written data.
- R3: A cycle with `key_valid` high stores `key_byte` and sets keyboard ready on that clock edge. Reading 0xFE02 returns the stored byte in bits 7:0, with bits 15:8 zero.
- R4: A cycle with `cpu_rd` high at 0xFE02 clears keyboard ready on that edge. If `key_valid` is high in the same cycle, ready stays set and the new byte is stored. A read with `cpu_rd` low changes nothing.
- R5: Reading 0xFE04 returns console done in bit 15 and the console interrupt enable in bit 14, with other bits zero. Only bit 14 is writable. After reset done is 1 and the enable is 0.
- R6: A write to 0xFE06 puts data bits 7:0 on `disp_byte` and raises `disp_valid` from the next cycle, which clears done. `disp_valid` and `disp_byte` hold until a cycle with `disp_ack` high, after which `disp_valid` is low and done is set. A write in the same cycle as `disp_ack` wins. Reading 0xFE06 returns the last byte written.
- R7: `run` is 1 after reset. A write to 0xFFFE sets `run` to bit 15 of the data, and `run` changes on no other event.
- R8: `key_irq` is high exactly when keyboard ready and its enable are both set. `disp_irq` is high exactly when console done and its enable are both set.
- R9: Window addresses other than the five registers read as zero, and writes to them change no register. Addresses below the window also read as zero.
- R10: Reset, applied asynchronously and released after two clock edges, clears keyboard ready, both enables, the stored bytes and `disp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Word address of the CPU access |
| cpu_we | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe; consumes the keyboard byte at 0xFE02 |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed register (combinational) |
| mem_sel | output | 1 | Memory array select, low inside the device window |
| key_valid | input | 1 | Keyboard presents a byte this cycle |
| key_byte | input | 8 | Keyboard character code |
| disp_valid | output | 1 | Console byte waiting for acknowledge |
| disp_byte | output | 8 | Console character code |
| disp_ack | input | 1 | Console has taken the byte |
| key_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Console interrupt request |
| run | output | 1 | Run latch |

## Verification
The bench targets collisions between events. A keystroke that arrives in the same cycle as the consuming read must leave ready set. A design that lets the read win would lose that keystroke. A console write that coincides with an acknowledge must leave the new byte pending. A design that lets the acknowledge win would report done for a byte the display never saw. Writes of all-ones to status registers check that ready and done cannot be forced by software. Writes to unmapped window words, followed by readback of the real registers, catch a decoder that aliases addresses. Peeks without the read strobe catch a design that consumes the byte on any address match.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int CHAR_W  = 8;
  localparam int RDY_BIT = 15;
  localparam int IE_BIT  = 14;
  localparam int RUN_BIT = 15;

  localparam logic [15:0] WIN_BASE = 16'hFE00;
  localparam logic [15:0] KEY_STAT = 16'hFE00;
  localparam logic [15:0] KEY_DATA = 16'hFE02;
  localparam logic [15:0] CON_STAT = 16'hFE04;
  localparam logic [15:0] CON_DATA = 16'hFE06;
  localparam logic [15:0] CTL_REG  = 16'hFFFE;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_CSTAT,
    SEL_CDATA,
    SEL_CTL
  } reg_sel_e;
endpackage

// File: rtl/io_win_rstsync.sv
module io_win_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/io_win_decode.sv
module io_win_decode
  import io_win_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output logic          in_win,
  output reg_sel_e      sel
);
  localparam logic [AW-1:0] BASE_A = AW'(WIN_BASE);
  localparam logic [AW-1:0] KST_A  = AW'(KEY_STAT);
  localparam logic [AW-1:0] KDT_A  = AW'(KEY_DATA);
  localparam logic [AW-1:0] CST_A  = AW'(CON_STAT);
  localparam logic [AW-1:0] CDT_A  = AW'(CON_DATA);
  localparam logic [AW-1:0] CTL_A  = AW'(CTL_REG);

  always_comb begin
    in_win = (addr >= BASE_A);
    sel    = SEL_NONE;
    if (in_win) begin
      case (addr)
        KST_A:   sel = SEL_KSTAT;
        KDT_A:   sel = SEL_KDATA;
        CST_A:   sel = SEL_CSTAT;
        CDT_A:   sel = SEL_CDATA;
        CTL_A:   sel = SEL_CTL;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/io_win_keyin.sv
module io_win_keyin #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_byte,
  input  logic          rd_clr,
  input  logic          ie_wr,
  input  logic          ie_wdata,
  output logic          ready,
  output logic          ie,
  output logic [CW-1:0] byte_q
);
  logic          ready_q, ready_d;
  logic          ie_q, ie_d;
  logic [CW-1:0] byte_r, byte_d;

  always_comb begin
    ready_d = ready_q;
    byte_d  = byte_r;
    ie_d    = ie_q;
    if (rd_clr) ready_d = 1'b0;
    if (in_valid) begin
      ready_d = 1'b1;
      byte_d  = in_byte;
    end
    if (ie_wr) ie_d = ie_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ie_q    <= 1'b0;
      byte_r  <= '0;
    end else begin
      ready_q <= ready_d;
      if (ie_wr)    ie_q   <= ie_d;
      if (in_valid) byte_r <= byte_d;
    end
  end

  assign ready  = ready_q;
  assign ie     = ie_q;
  assign byte_q = byte_r;
endmodule

// File: rtl/io_win_conout.sv
module io_win_conout #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_byte,
  input  logic [CW-1:0] wdata,
  input  logic          ack,
  input  logic          ie_wr,
  input  logic          ie_wdata,
  output logic          pend,
  output logic          ie,
  output logic [CW-1:0] byte_q
);
  logic          pend_q, pend_d;
  logic          ie_q, ie_d;
  logic [CW-1:0] byte_r, byte_d;

  always_comb begin
    pend_d = pend_q;
    byte_d = byte_r;
    ie_d   = ie_q;
    if (ack) pend_d = 1'b0;
    if (wr_byte) begin
      pend_d = 1'b1;
      byte_d = wdata;
    end
    if (ie_wr) ie_d = ie_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
      byte_r <= '0;
    end else begin
      pend_q <= pend_d;
      if (ie_wr)   ie_q   <= ie_d;
      if (wr_byte) byte_r <= byte_d;
    end
  end

  assign pend   = pend_q;
  assign ie     = ie_q;
  assign byte_q = byte_r;
endmodule

// File: rtl/io_win_runlatch.sv
module io_win_runlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic run
);
  logic run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (wr) run_d = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
    end else if (wr) begin
      run_q <= run_d;
    end
  end

  assign run = run_q;
endmodule

// File: rtl/io_window.sv
module io_window
  import io_win_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_we,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_sel,
  input  logic          key_valid,
  input  logic [CW-1:0] key_byte,
  output logic          disp_valid,
  output logic [CW-1:0] disp_byte,
  input  logic          disp_ack,
  output logic          key_irq,
  output logic          disp_irq,
  output logic          run
);
  logic          rst_sync_n;
  logic          in_win;
  reg_sel_e      sel;
  logic          key_ready, key_ie;
  logic [CW-1:0] key_q;
  logic          con_pend, con_ie, con_done;
  logic [CW-1:0] con_q;
  logic          wr_kstat, wr_cstat, wr_cdata, wr_ctl, rd_kdata;

  io_win_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  io_win_decode #(.AW(AW)) u_dec (
    .addr   (cpu_addr),
    .in_win (in_win),
    .sel    (sel)
  );

  assign wr_kstat = cpu_we && (sel == SEL_KSTAT);
  assign wr_cstat = cpu_we && (sel == SEL_CSTAT);
  assign wr_cdata = cpu_we && (sel == SEL_CDATA);
  assign wr_ctl   = cpu_we && (sel == SEL_CTL);
  assign rd_kdata = cpu_rd && (sel == SEL_KDATA);

  io_win_keyin #(.CW(CW)) u_key (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (key_valid),
    .in_byte  (key_byte),
    .rd_clr   (rd_kdata),
    .ie_wr    (wr_kstat),
    .ie_wdata (cpu_wdata[IE_BIT]),
    .ready    (key_ready),
    .ie       (key_ie),
    .byte_q   (key_q)
  );

  io_win_conout #(.CW(CW)) u_con (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_byte  (wr_cdata),
    .wdata    (cpu_wdata[CW-1:0]),
    .ack      (disp_ack),
    .ie_wr    (wr_cstat),
    .ie_wdata (cpu_wdata[IE_BIT]),
    .pend     (con_pend),
    .ie       (con_ie),
    .byte_q   (con_q)
  );

  io_win_runlatch u_run (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (wr_ctl),
    .wbit  (cpu_wdata[RUN_BIT]),
    .run   (run)
  );

  assign con_done = !con_pend;

  always_comb begin
    cpu_rdata = '0;
    case (sel)
      SEL_KSTAT: begin
        cpu_rdata[RDY_BIT] = key_ready;
        cpu_rdata[IE_BIT]  = key_ie;
      end
      SEL_KDATA: cpu_rdata[CW-1:0] = key_q;
      SEL_CSTAT: begin
        cpu_rdata[RDY_BIT] = con_done;
        cpu_rdata[IE_BIT]  = con_ie;
      end
      SEL_CDATA: cpu_rdata[CW-1:0] = con_q;
      SEL_CTL:   cpu_rdata[RUN_BIT] = run;
      default:   cpu_rdata = '0;
    endcase
  end

  assign mem_sel    = !in_win;
  assign disp_valid = con_pend;
  assign disp_byte  = con_q;
  assign key_irq    = key_ready && key_ie;
  assign disp_irq   = con_done && con_ie;
endmodule

// File: rtl/io_window_chk.sv
module io_window_chk
  import io_win_pkg::*;
(
  input logic        clk,
  input logic        rst_sync_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic        cpu_rd,
  input logic        mem_sel,
  input logic        key_valid,
  input logic        key_ready,
  input logic        key_ie,
  input logic        key_irq,
  input logic        disp_valid,
  input logic [7:0]  disp_byte,
  input logic        disp_ack,
  input logic        run
);
  AST_WIN_NO_MEM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_addr >= WIN_BASE) |-> !mem_sel); // R1

  AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_valid |=> key_ready); // R3

  AST_KEY_CONSUME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd && cpu_addr == KEY_DATA && !key_valid) |=> !key_ready); // R4

  AST_CON_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (disp_valid && !disp_ack && !(cpu_we && cpu_addr == CON_DATA))
      |=> (disp_valid && $stable(disp_byte))); // R6

  AST_CON_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (disp_ack && !(cpu_we && cpu_addr == CON_DATA)) |=> !disp_valid); // R6

  AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cpu_we && cpu_addr == CTL_REG) |=> $stable(run)); // R7

  AST_KEY_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_irq |-> (key_ready && key_ie)); // R8
endmodule

bind io_window io_window_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cpu_addr   (cpu_addr),
  .cpu_we     (cpu_we),
  .cpu_rd     (cpu_rd),
  .mem_sel    (mem_sel),
  .key_valid  (key_valid),
  .key_ready  (key_ready),
  .key_ie     (key_ie),
  .key_irq    (key_irq),
  .disp_valid (disp_valid),
  .disp_byte  (disp_byte),
  .disp_ack   (disp_ack),
  .run        (run)
);

// File: tb/io_window_bench.sv
module io_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // row: we, rd, addr[16], wdata[16], expected rdata[16], expected mem_sel, requirement number[4]
  localparam logic [54:0] TBL [0:NVEC-1] = '{
    {1'b0, 1'b1, 16'hFE00, 16'h0000, 16'h0000, 1'b0, 4'd10},
    {1'b0, 1'b1, 16'hFE02, 16'h0000, 16'h0000, 1'b0, 4'd10},
    {1'b0, 1'b1, 16'hFE04, 16'h0000, 16'h8000, 1'b0, 4'd5},
    {1'b0, 1'b1, 16'hFE06, 16'h0000, 16'h0000, 1'b0, 4'd10},
    {1'b0, 1'b1, 16'hFFFE, 16'h0000, 16'h8000, 1'b0, 4'd7},
    {1'b1, 1'b0, 16'hFE00, 16'hFFFF, 16'h0000, 1'b0, 4'd2},
    {1'b0, 1'b1, 16'hFE00, 16'h0000, 16'h4000, 1'b0, 4'd2},
    {1'b1, 1'b0, 16'hFE04, 16'h4000, 16'h0000, 1'b0, 4'd5},
    {1'b0, 1'b1, 16'hFE04, 16'h0000, 16'hC000, 1'b0, 4'd5},
    {1'b0, 1'b1, 16'hFE08, 16'h0000, 16'h0000, 1'b0, 4'd9},
    {1'b1, 1'b0, 16'hFE08, 16'hFFFF, 16'h0000, 1'b0, 4'd9},
    {1'b0, 1'b1, 16'hFE00, 16'h0000, 16'h4000, 1'b0, 4'd9},
    {1'b0, 1'b1, 16'h3000, 16'h0000, 16'h0000, 1'b1, 4'd1},
    {1'b0, 1'b1, 16'hFDFF, 16'h0000, 16'h0000, 1'b1, 4'd1},
    {1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 4'd9},
    {1'b0, 1'b1, 16'hFFFE, 16'h0000, 16'h8000, 1'b0, 4'd9},
    {1'b1, 1'b0, 16'hFE00, 16'h0000, 16'h0000, 1'b0, 4'd2},
    {1'b0, 1'b1, 16'hFE00, 16'h0000, 16'h0000, 1'b0, 4'd2}
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic        cpu_rd;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        mem_sel;
  logic        key_valid;
  logic [7:0]  key_byte;
  logic        disp_valid;
  logic [7:0]  disp_byte;
  logic        disp_ack;
  logic        key_irq;
  logic        disp_irq;
  logic        run;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  io_window u_io_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_we     (cpu_we),
    .cpu_rd     (cpu_rd),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .mem_sel    (mem_sel),
    .key_valid  (key_valid),
    .key_byte   (key_byte),
    .disp_valid (disp_valid),
    .disp_byte  (disp_byte),
    .disp_ack   (disp_ack),
    .key_irq    (key_irq),
    .disp_irq   (disp_irq),
    .run        (run)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives one access just after an edge, samples the combinational read data
  // before the next edge, and returns one time unit after that edge
  task automatic acc(input logic we, input logic rd, input logic [15:0] a,
                     input logic [15:0] d, output logic [15:0] rv, output logic ms);
    cpu_we = we; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    #1;
    rv = cpu_rdata;
    ms = mem_sel;
    @(posedge clk); #1;
    cpu_we = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic peek(input logic [15:0] a, output logic [15:0] rv);
    cpu_addr = a; #1; rv = cpu_rdata;
  endtask

  task automatic start_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic        ms;
    cpu_addr = 16'h0000; cpu_we = 1'b0; cpu_rd = 1'b0; cpu_wdata = 16'h0000;
    key_valid = 1'b0; key_byte = 8'h00; disp_ack = 1'b0;
    rst_n = 1'b0;
    #1;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R10 reset state at the ports
    check("R10 run after reset", {15'b0, run}, 16'h0001);
    check("R10 disp_valid after reset", {15'b0, disp_valid}, 16'h0000);
    check("R8 irqs after reset", {14'b0, key_irq, disp_irq}, 16'h0000);

    // table walk: R1 R2 R5 R7 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [54:0] v;
      string tg;
      v = TBL[i];
      acc(v[54], v[53], v[52:37], v[36:21], rv, ms);
      tg = $sformatf("R%0d vec%0d", v[3:0], i);
      check({tg, " mem_sel"}, {15'b0, ms}, {15'b0, v[4]});
      if (v[53]) check({tg, " rdata"}, rv, v[20:5]);
    end

    // R8: console done and enable set, keyboard not ready
    check("R8 disp_irq done+ie", {15'b0, disp_irq}, 16'h0001);
    check("R8 key_irq idle", {15'b0, key_irq}, 16'h0000);

    // R3 keystroke capture
    key_valid = 1'b1; key_byte = 8'h41;
    idle(1);
    key_valid = 1'b0; key_byte = 8'h00;
    peek(16'hFE00, rv); check("R3 ready set", rv, 16'h8000);
    check("R8 key_irq no enable", {15'b0, key_irq}, 16'h0000);
    peek(16'hFE02, rv); check("R3 byte stored", rv, 16'h0041);
    peek(16'hFE00, rv); check("R4 peek keeps ready", rv, 16'h8000);
    acc(1'b1, 1'b0, 16'hFE00, 16'h4000, rv, ms);
    check("R8 key_irq ready+ie", {15'b0, key_irq}, 16'h0001);
    acc(1'b0, 1'b1, 16'hFE02, 16'h0000, rv, ms);
    check("R3 read returns byte", rv, 16'h0041);
    peek(16'hFE00, rv); check("R4 read clears ready", rv, 16'h4000);
    check("R8 key_irq cleared", {15'b0, key_irq}, 16'h0000);

    // R4 keystroke colliding with the consuming read
    key_valid = 1'b1; key_byte = 8'h42;
    idle(1);
    key_byte = 8'h43; cpu_rd = 1'b1; cpu_addr = 16'hFE02;
    #1; rv = cpu_rdata;
    check("R4 collide read value", rv, 16'h0042);
    @(posedge clk); #1;
    key_valid = 1'b0; cpu_rd = 1'b0;
    peek(16'hFE00, rv); check("R4 collide ready kept", rv, 16'hC000);
    peek(16'hFE02, rv); check("R4 collide new byte", rv, 16'h0043);
    acc(1'b0, 1'b1, 16'hFE02, 16'h0000, rv, ms);

    // R6 console byte handshake
    acc(1'b1, 1'b0, 16'hFE06, 16'h1F5A, rv, ms);
    check("R6 valid after write", {15'b0, disp_valid}, 16'h0001);
    check("R6 byte presented", {8'h00, disp_byte}, 16'h005A);
    peek(16'hFE04, rv); check("R6 done cleared", rv, 16'h4000);
    check("R8 disp_irq while busy", {15'b0, disp_irq}, 16'h0000);
    idle(3);
    check("R6 valid held", {15'b0, disp_valid}, 16'h0001);
    disp_ack = 1'b1; idle(1); disp_ack = 1'b0;
    check("R6 valid dropped", {15'b0, disp_valid}, 16'h0000);
    peek(16'hFE04, rv); check("R6 done set", rv, 16'hC000);
    check("R8 disp_irq after ack", {15'b0, disp_irq}, 16'h0001);
    peek(16'hFE06, rv); check("R6 readback", rv, 16'h005A);

    // R6 write in the same cycle as acknowledge
    acc(1'b1, 1'b0, 16'hFE06, 16'h0033, rv, ms);
    disp_ack = 1'b1;
    acc(1'b1, 1'b0, 16'hFE06, 16'h0044, rv, ms);
    disp_ack = 1'b0;
    check("R6 write beats ack valid", {15'b0, disp_valid}, 16'h0001);
    check("R6 write beats ack byte", {8'h00, disp_byte}, 16'h0044);
    disp_ack = 1'b1; idle(1); disp_ack = 1'b0;
    check("R6 second ack", {15'b0, disp_valid}, 16'h0000);

    // R7 run latch
    acc(1'b1, 1'b0, 16'hFFFE, 16'h7FFF, rv, ms);
    check("R7 halt", {15'b0, run}, 16'h0000);
    peek(16'hFFFE, rv); check("R7 halt readback", rv, 16'h0000);
    acc(1'b1, 1'b0, 16'hFE06, 16'hFFFF, rv, ms);
    check("R7 other write keeps run", {15'b0, run}, 16'h0000);
    acc(1'b1, 1'b0, 16'hFFFE, 16'h8000, rv, ms);
    check("R7 rerun", {15'b0, run}, 16'h0001);

    // R10 reset in mid operation
    key_valid = 1'b1; key_byte = 8'h5C; idle(1); key_valid = 1'b0;
    acc(1'b1, 1'b0, 16'hFFFE, 16'h0000, rv, ms);
    start_reset();
    check("R10 run restored", {15'b0, run}, 16'h0001);
    check("R10 disp_valid cleared", {15'b0, disp_valid}, 16'h0000);
    check("R10 disp_byte cleared", {8'h00, disp_byte}, 16'h0000);
    peek(16'hFE00, rv); check("R10 key status cleared", rv, 16'h0000);
    peek(16'hFE02, rv); check("R10 key byte cleared", rv, 16'h0000);
    peek(16'hFE04, rv); check("R10 console status", rv, 16'h8000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule